// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Logic

A set of I/O sources shares one interrupt request line. Each source owns a small node with a pending flag. The request line is the OR of every node's pending flag. A processor-side responder sees the line and raises a single acknowledge. The acknowledge ripples through the nodes in chain order, one register stage per node. The first node that is pending when the acknowledge rises at its input keeps the acknowledge. That node stops the ripple and places its 8-bit vector on a shared vector bus. The responder reads the bus, reports the vector and drops the acknowledge. The winning node then clears its pending flag.

Priority is fixed by position, so the node nearest the responder wins. A source may also withdraw a request that has not yet been served. When that happens, the acknowledge can run off the far end of the chain with no taker, and the responder reports a spurious interrupt. Each node decides whether to keep or forward at the moment the acknowledge rises at its input. A request that arrives after the acknowledge has passed a node is therefore served in a later round.

Each node has three phases: WAIT (no acknowledge present), HOLD (acknowledge kept, vector driven) and PASS (acknowledge forwarded). The transitions are:
- WAIT→HOLD when the acknowledge rises while the node is pending.
- WAIT→PASS when the acknowledge rises while the node is not pending.
- HOLD→WAIT and PASS→WAIT when the acknowledge falls.

The responder has four states: IDLE, ACK, DROP and GAP. The transitions are:
- IDLE→ACK when the request line is high.
- ACK→DROP when a node claims the bus, or when the acknowledge emerges from the last node.
- DROP→GAP after one cycle.
- GAP→IDLE after one cycle.

Top module: `irq_daisy_chain`

## Requirements
- R1: After reset the request line, acknowledge, vector bus, vector-valid, spurious flag and all pending flags are 0. A raise pulse sets that node's pending flag on the next clock edge. The request line is high exactly while any pending flag is set.
- R2: The responder raises the acknowledge only after seeing the request line high, and runs one round at a time. It lowers the acknowledge in the cycle in which it reports either a vector or a spurious interrupt.
- R3: A node that is not pending when the acknowledge rises at its input forwards it one cycle later. A pending node keeps it and does not forward it.
- R4: When several nodes are pending together, they are served in ascending index order, with index 0 nearest the responder, one per round.
- R5: Node k's vector is VEC_BASE + k*VEC_STEP, truncated to 8 bits. A node drives the vector bus only while it holds the acknowledge. The bus is 0 whenever the acknowledge is low.
- R6: A request raised after the acknowledge has already passed a node is not served in that round. It is served in the next round.
- R7: The winner clears its pending flag when the acknowledge falls after its vector has been read. Each raise is served exactly once. vec_valid is a one-cycle pulse.
- R8: If the acknowledge passes the last node with no taker, the responder pulses `spurious` and does not pulse vec_valid.
- R9: A withdraw pulse clears an unserved pending flag on the next edge. A raise in the same cycle takes precedence.
- R10: Take a lone raise for node k sampled at edge E0. Its vec_valid pulse is visible in the cycle after edge E0+k+3. Node k drives its vector in the cycle after edge E0+k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_raise | input | N | Per-source request pulse |
| src_withdraw | input | N | Per-source request withdrawal pulse |
| irq_line | output | 1 | Shared request line (OR of pending flags) |
| irq_ack | output | 1 | Acknowledge entering node 0 |
| vec_bus | output | 8 | Shared vector bus (OR of node drivers) |
| vec_valid | output | 1 | One-cycle pulse: vec_value holds a fresh vector |
| vec_value | output | 8 | Last vector read by the responder |
| spurious | output | 1 | One-cycle pulse: acknowledge found no taker |
| pending | output | N | Per-node pending flags |

## Verification
The bench builds the block with four nodes, a vector base of 0x40 and a step of 4. This makes every one of the 15 non-empty combinations of simultaneous requests small enough to apply in full. For each combination the bench checks the full service order and the first-vector latency, both derived from the lowest set index. The small chain also places exact cycle targets within reach:
- a late request to node 0 that must be skipped while node 3 is served;
- a withdrawal that must let the acknowledge run off the end of the chain.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    typedef enum logic [1:0] {PH_WAIT, PH_HOLD, PH_PASS} node_phase_t;
    typedef enum logic [1:0] {RS_IDLE, RS_ACK, RS_DROP, RS_GAP} resp_state_t;
endpackage

// File: rtl/irq_chain_node.sv
module irq_chain_node
    import irq_chain_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] VECTOR = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise,
    input  logic             withdraw,
    input  logic             ack_in,
    input  logic             rd_strobe,
    output logic             pending,
    output logic             ack_out,
    output logic             drive_en,
    output logic [VEC_W-1:0] vec_out
);
    node_phase_t phase_q, phase_d;
    logic ack_in_q;
    logic pend_q, pend_d;
    logic got_read_q, got_read_d;
    logic ack_rise, clear;

    assign ack_rise = ack_in && !ack_in_q;
    assign clear    = (phase_q == PH_HOLD) && !ack_in && got_read_q;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_WAIT: if (ack_rise) phase_d = pend_q ? PH_HOLD : PH_PASS;
            PH_HOLD: if (!ack_in)  phase_d = PH_WAIT;
            PH_PASS: if (!ack_in)  phase_d = PH_WAIT;
            default: phase_d = PH_WAIT;
        endcase
        pend_d     = raise || (pend_q && !withdraw && !clear);
        got_read_d = (phase_q == PH_HOLD) && ack_in && (got_read_q || rd_strobe);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_WAIT;
            ack_in_q   <= 1'b0;
            pend_q     <= 1'b0;
            got_read_q <= 1'b0;
        end else begin
            phase_q    <= phase_d;
            ack_in_q   <= ack_in;
            pend_q     <= pend_d;
            got_read_q <= got_read_d;
        end
    end

    always_comb begin
        pending  = pend_q;
        ack_out  = ack_in && (phase_q == PH_PASS);
        drive_en = ack_in && (phase_q == PH_HOLD);
        vec_out  = drive_en ? VECTOR : '0;
    end
endmodule

// File: rtl/irq_chain_responder.sv
module irq_chain_responder
    import irq_chain_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_line,
    input  logic             claim,
    input  logic             chain_end,
    input  logic [VEC_W-1:0] bus,
    output logic             ack,
    output logic             rd_strobe,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_value,
    output logic             spurious
);
    resp_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_IDLE: if (irq_line) st_d = RS_ACK;
            RS_ACK:  if (claim || chain_end) st_d = RS_DROP;
            RS_DROP: st_d = RS_GAP;
            RS_GAP:  st_d = RS_IDLE;
            default: st_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RS_IDLE;
        else        st_q <= st_d;
    end

    assign ack       = (st_q == RS_ACK);
    assign rd_strobe = (st_q == RS_ACK) && claim;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_value <= '0;
            spurious  <= 1'b0;
        end else begin
            vec_valid <= rd_strobe;
            if (rd_strobe) vec_value <= bus;
            spurious  <= (st_q == RS_ACK) && !claim && chain_end;
        end
    end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
    parameter int N         = 4,
    parameter int VEC_W     = 8,
    parameter int VEC_BASE  = 64,
    parameter int VEC_STEP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     src_raise,
    input  logic [N-1:0]     src_withdraw,
    output logic             irq_line,
    output logic             irq_ack,
    output logic [VEC_W-1:0] vec_bus,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_value,
    output logic             spurious,
    output logic [N-1:0]     pending
);
    logic [N:0]                ack_chain;
    logic [N-1:0]              drv_en;
    logic [N-1:0][VEC_W-1:0]   vec_arr;
    logic                      rd_strobe;
    logic                      claim;

    assign ack_chain[0] = irq_ack;

    for (genvar k = 0; k < N; k++) begin : g_node
        localparam logic [VEC_W-1:0] NODE_VEC = VEC_W'(VEC_BASE + VEC_STEP * k);
        irq_chain_node #(.VEC_W(VEC_W), .VECTOR(NODE_VEC)) u_node (
            .clk      (clk),
            .rst_n    (rst_n),
            .raise    (src_raise[k]),
            .withdraw (src_withdraw[k]),
            .ack_in   (ack_chain[k]),
            .rd_strobe(rd_strobe),
            .pending  (pending[k]),
            .ack_out  (ack_chain[k+1]),
            .drive_en (drv_en[k]),
            .vec_out  (vec_arr[k])
        );
    end

    always_comb begin
        vec_bus = '0;
        for (int i = 0; i < N; i++) vec_bus = vec_bus | vec_arr[i];
    end

    assign irq_line = |pending;
    assign claim    = |drv_en;

    irq_chain_responder #(.VEC_W(VEC_W)) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_line (irq_line),
        .claim    (claim),
        .chain_end(ack_chain[N]),
        .bus      (vec_bus),
        .ack      (irq_ack),
        .rd_strobe(rd_strobe),
        .vec_valid(vec_valid),
        .vec_value(vec_value),
        .spurious (spurious)
    );
endmodule

// File: rtl/irq_daisy_chain_chk.sv
module irq_daisy_chain_chk #(
    parameter int N     = 4,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_line,
    input logic             irq_ack,
    input logic             vec_valid,
    input logic             spurious,
    input logic [VEC_W-1:0] vec_bus,
    input logic [N-1:0]     drv_en
);
    a_r5_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack |-> vec_bus == '0);
    a_r4_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_en));
    a_r2_ack_after_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ack) |-> $past(irq_line));
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid || spurious) |-> !irq_ack);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && spurious));
    a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(.N(N), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .irq_ack(irq_ack),
    .vec_valid(vec_valid), .spurious(spurious), .vec_bus(vec_bus), .drv_en(drv_en)
);

// File: tb/irq_daisy_chain_test.sv
module irq_daisy_chain_test;
    localparam int N = 4, VW = 8, BASE = 64, STEP = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] src_raise = '0, src_withdraw = '0;
    logic irq_line, irq_ack, vec_valid, spurious;
    logic [VW-1:0] vec_bus, vec_value;
    logic [N-1:0] pending;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_daisy_chain #(.N(N), .VEC_W(VW), .VEC_BASE(BASE), .VEC_STEP(STEP)) uut (
        .clk(clk), .rst_n(rst_n), .src_raise(src_raise), .src_withdraw(src_withdraw),
        .irq_line(irq_line), .irq_ack(irq_ack), .vec_bus(vec_bus), .vec_valid(vec_valid),
        .vec_value(vec_value), .spurious(spurious), .pending(pending));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int vec_of(input int k);
        return (BASE + STEP * k) & 255;
    endfunction

    // waits for vec_valid or spurious; kind 1 = vector, 2 = spurious, 0 = none
    task automatic wait_evt(inout int cnt, output int kind, output int val);
        kind = 0; val = 0;
        for (int t = 0; t < 100; t++) begin
            @(negedge clk); cnt++;
            if (cnt == 1) begin src_raise = '0; src_withdraw = '0; end
            if (vec_valid) begin kind = 1; val = int'(vec_value); return; end
            if (spurious)  begin kind = 2; return; end
        end
    endtask

    task automatic settle_check(input string tag);
        repeat (4) @(negedge clk);
        check(pending == '0, {"R7 pending cleared ", tag}, int'(pending), 0);
        check(!irq_line && vec_bus == '0, {"R5 idle bus ", tag}, int'(vec_bus), 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt, kind, val, low;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!irq_line && !irq_ack && vec_bus == '0 && !vec_valid && !spurious && pending == '0,
              "R1 reset state", int'(pending), 0);

        // exhaustive sweep of simultaneous request masks: R1 R3 R4 R5 R7 R10
        for (int m = 1; m < (1 << N); m++) begin
            low = -1;
            for (int i = N - 1; i >= 0; i--) if (m[i]) low = i;
            src_raise = N'(m); cnt = 0;
            @(negedge clk); cnt++; src_raise = '0;
            check(irq_line && pending == N'(m), "R1 line follows pending", int'(pending), m);
            while (cnt < low + 3) begin @(negedge clk); cnt++; end
            check(irq_ack && int'(vec_bus) == vec_of(low), "R5 winner drives bus", int'(vec_bus), vec_of(low));
            for (int i = 0; i < N; i++) begin
                if (!m[i]) continue;
                wait_evt(cnt, kind, val);
                check(kind == 1 && val == vec_of(i), "R4 service order", val, vec_of(i));
                if (i == low) check(cnt == low + 4, "R10 latency", cnt, low + 4);
                check(vec_bus == '0, "R2 ack released on report", int'(vec_bus), 0);
            end
            settle_check("sweep");
        end

        // late request to node 0 after ack passed it: R6 R3
        src_raise = 4'b1000; cnt = 0;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk); cnt++;
            if (cnt == 1) src_raise = '0;
            if (cnt == 3) begin
                check(irq_ack, "R3 ack travelling", int'(irq_ack), 1);
                src_raise = 4'b0001;
            end
            if (cnt == 4) src_raise = '0;
        end
        wait_evt(cnt, kind, val);
        check(kind == 1 && val == vec_of(3), "R6 passed node skipped", val, vec_of(3));
        check(cnt == 7, "R6 late raiser timing", cnt, 7);
        cnt = 10;
        wait_evt(cnt, kind, val);
        check(kind == 1 && val == vec_of(0), "R6 served next round", val, vec_of(0));
        settle_check("passby");

        // withdrawal before ack arrives: R9 R8
        src_raise = 4'b0100; cnt = 0;
        @(negedge clk); cnt++; src_raise = '0; src_withdraw = 4'b0100;
        @(negedge clk); cnt++; src_withdraw = '0;
        check(pending == '0 && !irq_line, "R9 withdraw clears", int'(pending), 0);
        wait_evt(cnt, kind, val);
        check(kind == 2, "R8 spurious flagged", kind, 2);
        check(cnt == 7, "R8 spurious timing", cnt, 7);
        settle_check("spurious");

        // raise and withdraw together: raise wins (R9)
        src_raise = 4'b0010; src_withdraw = 4'b0010; cnt = 0;
        wait_evt(cnt, kind, val);
        check(kind == 1 && val == vec_of(1), "R9 raise beats withdraw", val, vec_of(1));
        settle_check("both");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule